// File: doc/BRIEF.md
# Word-Interleaved Line Refill Controller

This block returns four-word cache lines from a memory that is split into independent banks. Consecutive word addresses fall into consecutive banks, so the words of one aligned line sit one per bank. When a line read is accepted, the controller starts the access in all banks at the same time. Each bank stays occupied for its full cycle time. When the banks finish, the words go back to the requester one per cycle over a single word-wide bus. A full line therefore costs one bank access plus one transfer cycle per word. Four serial accesses are never needed.

The same request port also carries single-word writes. A write occupies only the bank that holds its word, so writes to different banks can be accepted on consecutive cycles. Each bank has a countdown of its own that is loaded when an access starts. The request port only accepts work whose banks are all free and not already claimed by a request that is still being launched.

Top module: `ilv_line_ctrl`

## Requirements
- R1: Word address `a` is held in bank `a mod NBANK` at row `a / NBANK`. A read of line `L` returns the words at addresses `L*NBANK` through `L*NBANK+NBANK-1`.
- R2: Number the clock edge that accepts a read as edge 0. The banks start at edge 1. Word `k` of the line is on the output bus from edge `BANK_CYC+1+k` to the next edge, so with the defaults the first word appears after edge 11 and the last after edge 14.
- R3: The words of a line come out in ascending address order, in `NBANK` consecutive cycles with `rsp_valid` high. `rsp_last` is high only with the final word, and `rsp_valid` is low in the cycle after it.
- R4: A bank is never started again while its countdown is running. After a read accepted at edge 0, the next read is accepted at edge `BANK_CYC+2` at the earliest.
- R5: A write (`req_write`=1) stores `req_wdata` at one word and occupies only that word's bank. Writes to different banks can be accepted on back-to-back cycles. A second write to the same bank waits `BANK_CYC+2` edges.
- R6: A read needs every bank. A read offered after a write accepted at edge 0 is accepted at edge `BANK_CYC+2`.
- R7: After reset, `req_ready` is high, `rsp_valid` is low, and every memory word reads as zero.
- R8: The low `log2(NBANK)` address bits of a read are ignored. Any address inside a line returns that whole line, starting from its first word.
- R9: `req_ready` does not depend on `req_valid`. It is high whenever the banks that the offered request would need are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = single-word write, 0 = line read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read word on the bus |
| rsp_data | output | DW | Read word |
| rsp_last | output | 1 | Final word of the line |

## Verification
The edge that accepts a read is taken as the origin. The first word is due `BANK_CYC+1` edges later and the last `BANK_CYC+NBANK` edges later. Every bank is free for new work `BANK_CYC+1` edges after the accepting edge, so a new request can be accepted one edge after that. A behavioural model in the bench keeps, for each bank, the edge number after which it is free, and keeps a map from edge numbers to expected output words. On every cycle the bench drives its inputs at the falling edge and then compares `req_ready`, `rsp_valid`, `rsp_data` and `rsp_last` against the entry for the most recent rising edge. Separate checks measure the number of edges from acceptance to the first word, and between back-to-back acceptances.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Request kinds carried on req_write.
  typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} op_e;

  // Edge offset, counted from the accepting edge, of word k of a line.
  function automatic int unsigned word_due(input int unsigned cyc, input int unsigned k);
    return 1 + cyc + k;
  endfunction

  // Earliest edge offset at which a bank used by a request can be claimed again.
  function automatic int unsigned reclaim_after(input int unsigned cyc);
    return cyc + 2;
  endfunction
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int DW  = 32,
  parameter int IW  = 6,
  parameter int CYC = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          rd_done,
  output logic [DW-1:0] rdata
);
  localparam int CW    = $clog2(CYC + 1);
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt;
  logic          rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      rd_q  <= 1'b0;
      rdata <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (start) begin
      cnt  <= CW'(CYC);
      rd_q <= !we;
      if (we) mem[idx] <= wdata;
      else    rdata    <= mem[idx];
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign busy    = (cnt != '0);
  assign rd_done = rd_q && (cnt == CW'(1));
endmodule

// File: rtl/ilv_stream.sv
module ilv_stream #(
  parameter int DW = 32,
  parameter int NW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NW*DW-1:0] line_in,
  output logic             valid,
  output logic [DW-1:0]    data,
  output logic             last
);
  localparam int CW = $clog2(NW + 1);

  logic [NW*DW-1:0] sh;
  logic [CW-1:0]    left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (load) begin
      sh   <= line_in;
      left <= CW'(NW);
    end else if (left != '0) begin
      sh   <= sh >> DW;
      left <= left - CW'(1);
    end
  end

  assign valid = (left != '0);
  assign data  = sh[DW-1:0];
  assign last  = (left == CW'(1));
endmodule

// File: rtl/ilv_line_ctrl.sv
module ilv_line_ctrl
  import ilv_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int NBANK    = 4,
  parameter int BANK_CYC = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_last
);
  localparam int LB = $clog2(NBANK);
  localparam int IW = AW - LB;

  // Banks a request occupies: all of them for a read, one for a write.
  function automatic logic [NBANK-1:0] need_mask(input logic wr, input logic [AW-1:0] a);
    logic [NBANK-1:0] m;
    if (wr == OP_WRITE) begin
      m = '0;
      m[a[LB-1:0]] = 1'b1;
    end else begin
      m = '1;
    end
    return m;
  endfunction

  logic             acc;
  logic             pend_q;
  logic             pwe_q;
  logic [AW-1:0]    paddr_q;
  logic [DW-1:0]    pdata_q;
  logic [NBANK-1:0] resv;
  logic [NBANK-1:0] bank_busy;
  logic [NBANK-1:0] bank_start;
  logic [NBANK-1:0] bank_rdone;
  logic             line_done;
  logic [NBANK*DW-1:0] line_word;

  assign resv      = pend_q ? need_mask(pwe_q, paddr_q) : '0;
  assign req_ready = ((bank_busy | resv) & need_mask(req_write, req_addr)) == '0;
  assign acc       = req_valid & req_ready;

  // Address cycle: the accepted request is held one cycle before the banks start.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pwe_q   <= 1'b0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      pend_q <= acc;
      if (acc) begin
        pwe_q   <= req_write;
        paddr_q <= req_addr;
        pdata_q <= req_wdata;
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_start[b] = resv[b];
    ilv_bank #(.DW(DW), .IW(IW), .CYC(BANK_CYC)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (bank_start[b]),
      .we      (pwe_q),
      .idx     (paddr_q[AW-1:LB]),
      .wdata   (pdata_q),
      .busy    (bank_busy[b]),
      .rd_done (bank_rdone[b]),
      .rdata   (line_word[b*DW +: DW])
    );
  end

  assign line_done = &bank_rdone;

  ilv_stream #(.DW(DW), .NW(NBANK)) u_stream (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (line_done),
    .line_in (line_word),
    .valid   (rsp_valid),
    .data    (rsp_data),
    .last    (rsp_last)
  );
endmodule

// File: rtl/ilv_line_ctrl_chk.sv
module ilv_line_ctrl_chk #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc,
  input logic [NBANK-1:0] bank_start,
  input logic [NBANK-1:0] bank_busy,
  input logic             line_done,
  input logic             rsp_valid,
  input logic             rsp_last
);
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_start & bank_busy) == '0); // R4
  AST_LAUNCH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (bank_start != '0)); // R2
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |=> !rsp_valid); // R3
  AST_STREAM_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last) |=> rsp_valid); // R3
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> !rsp_valid); // R4
endmodule

bind ilv_line_ctrl ilv_line_ctrl_chk #(.NBANK(NBANK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc        (acc),
  .bank_start (bank_start),
  .bank_busy  (bank_busy),
  .line_done  (line_done),
  .rsp_valid  (rsp_valid),
  .rsp_last   (rsp_last)
);

// File: tb/ilv_line_ctrl_tb_top.sv
module ilv_line_ctrl_tb_top;
  localparam int DW  = 32;
  localparam int AW  = 8;
  localparam int NB  = 4;
  localparam int CYC = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_last;
  logic [DW-1:0] rsp_data;

  always #2 clk = ~clk;

  ilv_line_ctrl #(.DW(DW), .AW(AW), .NBANK(NB), .BANK_CYC(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last));

  // Reference model state
  int edge_n = 0;
  int avail[NB];
  logic [DW-1:0] mdl[1<<AW];
  logic [DW-1:0] exp_d[int];
  bit exp_l[int];
  int last_acc;
  int n_run = 0, n_fail = 0;
  bit ended = 0;

  always @(posedge clk) edge_n <= edge_n + 1;

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) if (edge_n > 20000) begin
    n_fail++;
    $display("FAIL watchdog actual=%0d expected<=20000 edges", edge_n);
    summary();
  end

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit model_ready(input bit we, input int addr);
    bit r = 1;
    for (int b = 0; b < NB; b++)
      if ((!we || (addr % NB) == b) && edge_n < avail[b]) r = 0;
    return r;
  endfunction

  // One cycle: drive at the falling edge, compare, then update the model for the next edge.
  task automatic step(input string tag, input bit v, input bit we, input int addr,
                      input logic [DW-1:0] wd, output bit took);
    bit er;
    int e;
    @(negedge clk);
    req_valid = v; req_write = we; req_addr = AW'(addr); req_wdata = wd;
    #1;
    er = model_ready(we, addr);
    chk(tag, "req_ready", DW'(req_ready), DW'(er));
    if (exp_d.exists(edge_n)) begin
      chk(tag, "rsp_valid", DW'(rsp_valid), DW'(1));
      chk(tag, "rsp_data", rsp_data, exp_d[edge_n]);
      chk(tag, "rsp_last", DW'(rsp_last), DW'(exp_l[edge_n]));
    end else begin
      chk(tag, "rsp_valid", DW'(rsp_valid), DW'(0));
    end
    took = v && er;
    if (took) begin
      e = edge_n + 1;
      last_acc = e;
      if (we) begin
        mdl[addr] = wd;
        avail[addr % NB] = e + CYC + 1;
      end else begin
        for (int k = 0; k < NB; k++) begin
          exp_d[e + CYC + 1 + k] = mdl[(addr / NB) * NB + k];
          exp_l[e + CYC + 1 + k] = (k == NB - 1);
        end
        for (int b = 0; b < NB; b++) avail[b] = e + CYC + 1;
      end
    end
  endtask

  task automatic issue(input string tag, input bit we, input int addr, input logic [DW-1:0] wd);
    bit t = 0;
    int guard = 0;
    while (!t && guard < 100) begin
      step(tag, 1, we, addr, wd, t);
      guard++;
    end
  endtask

  task automatic idle(input string tag, input int n);
    bit t;
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, '0, t);
  endtask

  // Read a line and measure the first and last word against the accepting edge.
  task automatic read_line(input string tag, input int addr);
    int e0, first, lastw, i;
    bit t;
    issue(tag, 0, addr, '0);
    e0 = last_acc; first = -1; lastw = -1; i = 0;
    while (lastw < 0 && i < 40) begin
      step(tag, 0, 0, 0, '0, t);
      if (rsp_valid && first < 0) first = edge_n;
      if (rsp_valid && rsp_last) lastw = edge_n;
      i++;
    end
    chk("R2", "first word edge offset", DW'(first - e0), DW'(CYC + 1));
    chk("R2", "last word edge offset", DW'(lastw - e0), DW'(CYC + NB));
  endtask

  initial begin
    int a0, a1;
    for (int b = 0; b < NB; b++) avail[b] = 0;
    for (int i = 0; i < (1 << AW); i++) mdl[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R7: reset state and cleared memory
    @(negedge clk); #1;
    chk("R7", "req_ready after reset", DW'(req_ready), DW'(1));
    chk("R7", "rsp_valid after reset", DW'(rsp_valid), DW'(0));
    read_line("R7", 36);

    // R9: ready high with valid low while idle
    idle("R9", 3);

    // R5: writes to banks 0..3 on consecutive edges
    issue("R5", 1, 0, 32'hA000_0000);
    a0 = last_acc;
    for (int w = 1; w < NB; w++) issue("R5", 1, w, 32'hA000_0000 + w);
    chk("R5", "4 writes to distinct banks span", DW'(last_acc - a0), DW'(NB - 1));
    // R5: same-bank write waits
    a0 = last_acc - (NB - 1);
    issue("R5", 1, 4, 32'hA000_0004);
    chk("R5", "same-bank write delay", DW'(last_acc - a0), DW'(CYC + 2));
    for (int w = 5; w < 16; w++) issue("R5", 1, w, 32'hA000_0000 + w * 32'h11);

    // R6: read waits for the write's bank
    a0 = last_acc;
    issue("R6", 0, 4, '0);
    chk("R6", "read after write accept delay", DW'(last_acc - a0), DW'(CYC + 2));
    idle("R1", CYC + NB + 2);

    // R1, R3: line contents and order
    read_line("R1", 12);
    read_line("R3", 0);

    // R8: low address bits ignored
    read_line("R8", 10);

    // R4: back-to-back reads
    issue("R4", 0, 4, '0);
    a1 = last_acc;
    issue("R4", 0, 8, '0);
    chk("R4", "read to read accept delay", DW'(last_acc - a1), DW'(CYC + 2));
    idle("R4", CYC + NB + 4);

    summary();
  end
endmodule